// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Half-Line Eliminator

This block receives a composite sync bit that an analog slicer has already produced. The bit is active low and asynchronous to the system clock. From it the block produces a clean horizontal pulse once per video line. The equalizing and serration pulses inside vertical blanking come at twice the line rate, and they do not reach the horizontal output. Stray pulses that follow the true sync within a line, such as copy-protection pulses, are also rejected. The block learns the line period by timing the interval between the falling edges it accepts. After each accepted edge it blocks any new trigger until three quarters of that period have passed. Every trigger produces one low pulse of fixed length. The pulse is longer for standard-definition line rates and shorter for high-definition ones.

Alongside the horizontal output, the block passes the composite sync through, delayed by the same number of cycles. It also drives an active-low flag that marks a high-definition line rate. Before the block locks, and after it loses the input, all three outputs sit at fixed idle levels. All timing is counted in system clock cycles. With the default parameters one cycle is 0.5 µs: a standard line is about 127 cycles, and the 20 kHz high-definition boundary is a period of 100 cycles.

Top module: `hsync_regen`

## Requirements
- R1: Once locked, `csync_out_n` reproduces `csync_in_n` delayed by three rising clock edges (two synchroniser stages plus the output register). For every accepted falling edge, `hsync_out_n` falls on the same clock edge as `csync_out_n`.
- R2: While the locked period is at least `HD_LIMIT` cycles, each horizontal pulse holds `hsync_out_n` low for exactly `W_SD` cycles (default 10).
- R3: While the locked period is below `HD_LIMIT` cycles, each horizontal pulse holds `hsync_out_n` low for exactly `W_HD` cycles (default 4).
- R4: When locked, a falling edge that arrives fewer than `P - floor(P/4)` cycles after the last accepted edge is ignored, where P is the locked period: it produces no pulse and does not restart the line timer. An edge at exactly that distance is accepted. For P = 127 the boundary is 96 cycles.
- R5: Lock is reached on the third accepted falling edge after reset or loss of sync, provided the two measured intervals differ by at most `TOL` cycles (default 1). Pulses start from the fourth edge onward. If successive intervals never agree within `TOL`, no pulse is ever produced.
- R6: When no edge is accepted for more than twice the locked period, lock is lost. Until lock is regained, `hsync_out_n` stays high, `csync_out_n` stays low, `hd_out_n` stays high, and further input edges produce no pulse.
- R7: `hd_out_n` is low exactly when the block is locked and its period is below `HD_LIMIT` cycles (default 100, a 20 kHz line rate at a 2 MHz clock). It is updated one cycle after the lock state changes.
- R8: While `rst` is high and right after it is released, `hsync_out_n` = 1, `csync_out_n` = 0 and `hd_out_n` = 1.
- R9: Line intervals that alternate within `TOL` cycles of each other (for example 127 and 128) still lock the block and produce one pulse per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_in_n | input | 1 | Sliced composite sync, active low, asynchronous |
| csync_out_n | output | 1 | Delayed composite sync pass-through; low while unlocked |
| hsync_out_n | output | 1 | Regenerated horizontal pulse, active low; high while unlocked |
| hd_out_n | output | 1 | Low when the locked line rate is high definition |

## Verification
The bench feeds lines that contain half-line pulses and stray mid-line pulses. A design without the 75% gate would emit twice as many pulses there and would also lose its period measurement. Edges at 95 and 96 cycles after the last accepted edge probe the exact gate boundary, where an off-by-one comparison would fire a pulse too many or too few. Periods of 99 and 100 cycles test the definition boundary: a design with the wrong comparison would choose the wrong pulse width and flag. Further tests cover line intervals that never agree, which must never lock; intervals jittering by one cycle, which must lock; and a silent input, which must drop lock after twice the period rather than hold a stale state.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    // Line tracker lock progression
    typedef enum logic [1:0] {
        TRK_IDLE,   // no edge seen
        TRK_ONE,    // one edge seen, no interval yet
        TRK_CAND,   // one interval measured, awaiting a matching one
        TRK_LOCK    // period established
    } trk_state_e;

    // Synchronised input view
    typedef struct packed {
        logic level;  // synchronised sync level
        logic fall;   // one-cycle strobe on a high-to-low transition
    } edge_t;

    // Tracker result for the pulse generator and output stage
    typedef struct packed {
        logic locked; // period valid
        logic hd;     // period below high-definition limit
        logic fire;   // accepted edge while locked
    } trk_t;

    // Two interval values agree within a tolerance
    function automatic logic close_enough(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input logic [15:0] tol);
        logic [15:0] d;
        d = (a > b) ? (a - b) : (b - a);
        return d <= tol;
    endfunction

endpackage

// File: rtl/hsr_edge_in.sv
module hsr_edge_in
    import hsr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din_n,
    output edge_t ev_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din_n};
            last  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ev_o.level = chain[STAGES-1];
        ev_o.fall  = last & ~chain[STAGES-1];
    end
endmodule

// File: rtl/hsr_line_track.sv
module hsr_line_track
    import hsr_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int TOL      = 1,
    parameter int HD_LIMIT = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  edge_t ev_i,
    output trk_t  trk_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HD_LIM  = CNT_W'(HD_LIMIT);

    trk_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cand;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] thr;
    logic             accept;
    logic             matched;
    logic             stale;

    always_comb begin
        thr     = period - (period >> 2);
        accept  = ev_i.fall && ((st != TRK_LOCK) || (cnt >= thr));
        matched = close_enough(16'(cnt), 16'(cand), 16'(TOL));
        stale   = ({1'b0, cnt} > {period, 1'b0});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TRK_IDLE;
            cnt    <= '0;
            cand   <= '0;
            period <= '0;
        end else begin
            if (accept)
                cnt <= CNT_W'(1);
            else if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;

            if (accept) begin
                case (st)
                    TRK_IDLE: st <= TRK_ONE;
                    TRK_ONE: begin
                        st   <= TRK_CAND;
                        cand <= cnt;
                    end
                    TRK_CAND: begin
                        cand <= cnt;
                        if (matched) begin
                            st     <= TRK_LOCK;
                            period <= cnt;
                        end
                    end
                    TRK_LOCK: begin
                        cand <= cnt;
                        if (matched)
                            period <= cnt;
                    end
                endcase
            end else if (st == TRK_LOCK && stale) begin
                st <= TRK_IDLE;
            end
        end
    end

    always_comb begin
        trk_o.locked = (st == TRK_LOCK);
        trk_o.hd     = (period < HD_LIM);
        trk_o.fire   = accept && (st == TRK_LOCK);
    end

    // R4: an early edge while locked leaves the line timer running
    p_early_fall_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (st == TRK_LOCK && ev_i.fall && cnt < thr && cnt != CNT_MAX)
        |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen
    import hsr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int W_SD  = 10,
    parameter int W_HD  = 4
) (
    input  logic clk,
    input  logic rst,
    input  trk_t trk_i,
    output logic low_o
);
    localparam logic [CNT_W-1:0] SD_LOAD = CNT_W'(W_SD - 1);
    localparam logic [CNT_W-1:0] HD_LOAD = CNT_W'(W_HD - 1);

    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst || !trk_i.locked) begin
            low_o <= 1'b0;
            rem   <= '0;
        end else if (trk_i.fire) begin
            low_o <= 1'b1;
            rem   <= trk_i.hd ? HD_LOAD : SD_LOAD;
        end else if (low_o) begin
            if (rem != '0)
                rem <= rem - 1'b1;
            else
                low_o <= 1'b0;
        end
    end
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 10,
    parameter int TOL         = 1,
    parameter int HD_LIMIT    = 100,
    parameter int W_SD        = 10,
    parameter int W_HD        = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic csync_in_n,
    output logic csync_out_n,
    output logic hsync_out_n,
    output logic hd_out_n
);
    localparam int               WMAX   = (W_SD > W_HD) ? W_SD : W_HD;
    localparam logic [CNT_W-1:0] WMAX_C = CNT_W'(WMAX);

    edge_t ev;
    trk_t  trk;
    logic  h_low;
    logic  cs_q;
    logic  hd_n_q;

    hsr_edge_in #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .din_n (csync_in_n),
        .ev_o  (ev)
    );

    hsr_line_track #(.CNT_W(CNT_W), .TOL(TOL), .HD_LIMIT(HD_LIMIT)) u_track (
        .clk   (clk),
        .rst   (rst),
        .ev_i  (ev),
        .trk_o (trk)
    );

    hsr_pulse_gen #(.CNT_W(CNT_W), .W_SD(W_SD), .W_HD(W_HD)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .trk_i (trk),
        .low_o (h_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b0;
            hd_n_q <= 1'b1;
        end else begin
            cs_q   <= trk.locked & ev.level;
            hd_n_q <= ~(trk.locked & trk.hd);
        end
    end

    assign csync_out_n = cs_q;
    assign hsync_out_n = ~h_low;
    assign hd_out_n    = hd_n_q;

    // Assertion support: length of the current low run on the horizontal output
    logic [CNT_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (trk.fire)
            low_run <= CNT_W'(1);
        else if (!hsync_out_n && low_run != {CNT_W{1'b1}})
            low_run <= low_run + 1'b1;
        else if (hsync_out_n)
            low_run <= '0;
    end

    // R1: horizontal pulse starts together with the pass-through sync edge
    p_fire_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_out_n) |-> $fell(csync_out_n));

    // R2/R3: no pulse outlasts the longer configured width
    p_width_max_r2: assert property (@(posedge clk) disable iff (rst)
        !hsync_out_n |-> (low_run != '0 && low_run <= WMAX_C));

    // R6: pass-through forced low when not locked
    p_csync_lost_r6: assert property (@(posedge clk) disable iff (rst)
        !trk.locked |=> !csync_out_n);

    // R7: definition flag released when not locked
    p_hd_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
        !trk.locked |=> hd_out_n);
endmodule

// File: tb/hsync_regen_bench.sv
module hsync_regen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // period, sync low width, clean lines, lines with extra pulse, extra offset, expected width, expected hd_out_n
    localparam int VEC [NV][7] = '{
        '{127, 9, 8, 0,  0, 10, 1},
        '{127, 9, 5, 6, 63, 10, 1},
        '{127, 9, 5, 6, 30, 10, 1},
        '{ 44, 3, 8, 0,  0,  4, 0},
        '{ 44, 3, 5, 6, 22,  4, 0},
        '{ 99, 6, 6, 0,  0,  4, 0},
        '{100, 6, 6, 0,  0, 10, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b1;
    logic cs_o, h_o, hd_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    int hcount = 0;
    int run    = 0;
    int last_w = 0;
    int align_err = 0;
    bit clr = 0;
    logic prev_h  = 1'b1;
    logic prev_cs = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_regen u_hsync_regen (
        .clk         (clk),
        .rst         (rst),
        .csync_in_n  (din),
        .csync_out_n (cs_o),
        .hsync_out_n (h_o),
        .hd_out_n    (hd_o)
    );

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (clr) begin
            hcount = 0; run = 0; last_w = 0; align_err = 0;
        end else begin
            if (prev_h && !h_o) begin
                hcount++;
                if (!(prev_cs && !cs_o)) align_err++;
            end
            if (!h_o) run++;
            if (!prev_h && h_o) begin
                last_w = run;
                run = 0;
            end
        end
        prev_h  = h_o;
        prev_cs = cs_o;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = 1'b1;
        clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic line(input int p, input int l, input int x);
        for (int i = 0; i < p; i++) begin
            din = !((i < l) || (x != 0 && i >= x && i < x + 4));
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        // R8: reset state
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R8 hsync_out_n in reset", h_o, 1);
        check_eq("R8 csync_out_n in reset", cs_o, 0);
        check_eq("R8 hd_out_n in reset", hd_o, 1);
        do_reset();
        check_eq("R8 hsync_out_n after reset", h_o, 1);
        check_eq("R8 csync_out_n after reset", cs_o, 0);

        // Vector table
        for (int r = 0; r < NV; r++) begin
            do_reset();
            for (int n = 0; n < VEC[r][2]; n++) line(VEC[r][0], VEC[r][1], 0);
            for (int n = 0; n < VEC[r][3]; n++) line(VEC[r][0], VEC[r][1], VEC[r][4]);
            check_eq("R4/R5 pulse count", hcount, VEC[r][2] + VEC[r][3] - 3);
            check_eq(VEC[r][5] == 10 ? "R2 SD pulse width" : "R3 HD pulse width", last_w, VEC[r][5]);
            check_eq("R7 hd_out_n", hd_o, VEC[r][6]);
            check_eq("R1 pulse aligned with csync", align_err, 0);
            check_eq("R1 csync_out_n high between syncs", cs_o, 1);
        end

        // R1: latency of three edges
        do_reset();
        for (int n = 0; n < 5; n++) line(127, 9, 0);
        for (int i = 0; i < 127; i++) begin
            din = !(i < 9);
            @(negedge clk);
            if (i == 0) check_eq("R1 csync unchanged after 1 cycle", cs_o, 1);
            if (i == 1) check_eq("R1 csync unchanged after 2 cycles", cs_o, 1);
            if (i == 2) begin
                check_eq("R1 csync low after 3 cycles", cs_o, 0);
                check_eq("R1 hsync low with csync", h_o, 0);
            end
        end

        // R4: gate boundary at 96 cycles for period 127
        begin
            int h0;
            do_reset();
            for (int n = 0; n < 5; n++) line(127, 9, 0);
            h0 = hcount;
            line(95, 9, 0);
            line(32, 9, 0);
            check_eq("R4 edge at 95 ignored", hcount, h0 + 1);
            line(96, 9, 0);
            line(127, 9, 0);
            check_eq("R4 edge at 96 accepted", hcount, h0 + 3);
        end

        // R5: intervals never agree
        do_reset();
        for (int n = 0; n < 8; n++) line((n % 2 == 0) ? 127 : 140, 9, 0);
        check_eq("R5 no lock on disagreeing intervals", hcount, 0);
        check_eq("R5 csync held low unlocked", cs_o, 0);

        // R9: one-cycle jitter still locks
        do_reset();
        for (int n = 0; n < 8; n++) line((n % 2 == 0) ? 127 : 128, 9, 0);
        check_eq("R9 pulses with jitter", hcount, 5);

        // R6: loss of sync
        begin
            int h1;
            do_reset();
            for (int n = 0; n < 6; n++) line(127, 9, 0);
            din = 1'b1;
            repeat (117) @(negedge clk);
            check_eq("R6 still locked before 2P", cs_o, 1);
            repeat (20) @(negedge clk);
            check_eq("R6 csync low after loss", cs_o, 0);
            check_eq("R6 hsync high after loss", h_o, 1);
            check_eq("R6 hd_out_n high after loss", hd_o, 1);
            h1 = hcount;
            line(127, 9, 0);
            check_eq("R6 no pulse after loss", hcount, h1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R5 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule